// File: doc/BRIEF.md
# Phase-Control Triac Trigger Timer

This block fires a triac gate pulse a programmable time after a chosen edge of a synchronisation input. The sync input is normally a mains zero-crossing signal, and the pulse sets the conduction angle of an AC load under phase control. One of several sync pins is selected through a multiplexer. The pin can be inverted, and it is brought into the clock domain with a two-flop synchronizer. An edge detector then produces a one-cycle start strobe for a rising edge, a falling edge, or either edge.

All timing runs on a coarse internal tick with a fixed period of 25.6 µs. A free-running prescaler derives this tick from the system clock. Its division ratio is computed from the `CLK_HZ` parameter, so the delay does not depend on the system clock frequency.

- On a start strobe, a down-counter loads the latched delay. When the counter has run out on the tick, the gate goes active for a fixed number of ticks. The gate polarity can be inverted.
- Software writes a new delay into a holding register. It takes effect only from the next qualifying sync edge, and a flag shows that an update is still waiting.
- The sync edge is asynchronous to the tick, so the pulse position jitters by up to one tick. The block does not correct this.

Top module: `phase_trigger_timer`

## Requirements
- R1: The `edge_mode` input selects which edge of the effective sync level qualifies: 0 selects rising edges only, 1 selects falling edges only, and 2 or 3 selects both. A non-qualifying edge produces no gate pulse.
- R2: The tick period is TICK_DIV system clocks, with TICK_DIV = round(CLK_HZ × 25.6 µs). Every gate pulse is active for exactly PW_TICKS × TICK_DIV clock cycles.
- R3: Let the first clock edge that samples a new qualifying sync level be edge 0. With a latched delay D, the gate becomes active after an edge whose index lies between D×TICK_DIV+3 and D×TICK_DIV+TICK_DIV+2. This holds up to the largest delay, 2^DLY_W−1.
- R4: A delay of zero starts the gate pulse on the first tick after the start strobe, that is within 3 to TICK_DIV+2 edges of edge 0.
- R5: A value written with `dly_wr` is held and loaded only at the next qualifying sync edge. A delay already counting finishes with the value it was loaded with.
- R6: A qualifying sync edge that arrives while a delay or pulse is in progress restarts the delay from the latched value and ends any active pulse.
- R7: When `sync_inv` is 1, the selected pin is inverted before edge detection, so the edge roles swap.
- R8: When `gate_inv` is 1, `gate_out` idles high and pulses low. When `gate_inv` is 0, it idles low and pulses high.
- R9: Only the pin indexed by `sync_sel` can start a delay. Transitions on the other pins have no effect on `gate_out`.
- R10: `upd_pending` becomes 1 the cycle after a `dly_wr`. It returns to 0 once a qualifying edge loads that value, unless another write arrives in the same cycle.
- R11: After reset, `gate_out` sits at its inactive level and `upd_pending` is 0. No pulse appears until the first qualifying sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pins | input | N_SRC | Candidate sync inputs, asynchronous |
| sync_sel | input | SEL_W | Index of the pin used as sync |
| edge_mode | input | 2 | 0 rising, 1 falling, 2/3 both |
| sync_inv | input | 1 | Invert the selected sync pin |
| gate_inv | input | 1 | Invert the gate output polarity |
| dly_wdata | input | DLY_W | New delay in ticks |
| dly_wr | input | 1 | Write strobe for dly_wdata |
| gate_out | output | 1 | Triac gate pulse |
| upd_pending | output | 1 | A written delay is waiting for the next qualifying edge |

## Verification
A wrong prescaler count or a wrong pulse counter shows up at `gate_out` within a single pulse. Either the pulse width differs from PW_TICKS×TICK_DIV cycles, or the leading edge falls outside the one-tick jitter window.

A holding register that leaks into the running count moves the pulse of the delay already in progress. That error is therefore visible one sync period earlier than intended.

Edge-detector or multiplexer faults produce either a missing pulse or a pulse on a non-qualifying transition. Such a pulse appears within D+PW_TICKS+1 ticks of that transition. The bench sweeps every edge mode and inversion setting, and a range of delays from zero up to the maximum.

// File: rtl/ptt_pkg.sv
// Shared types and helpers for the phase-control trigger timer.
// Assumes the tick period is 25.6 us, i.e. 256 / 10 MHz.
package ptt_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_BOTH  = 2'd2,
        EDGE_BOTH2 = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2
    } core_state_e;

    // Rounded clock count for one 25.6 us tick, never below one.
    function automatic int tick_div_calc(input longint clk_hz);
        longint q;
        q = (clk_hz * 256 + 64'd5_000_000) / 64'd10_000_000;
        if (q < 1) q = 1;
        return int'(q);
    endfunction

endpackage

// File: rtl/ptt_prescaler.sv
// Free-running divider producing a one-cycle tick every DIV clocks.
// Assumes DIV >= 1; the count restarts at zero on reset.
module ptt_prescaler #(
    parameter int DIV = 4,
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          tick,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt;

    // Wrap the count at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(DIV - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick  = (cnt == CW'(DIV - 1));
    assign cnt_o = cnt;
endmodule

// File: rtl/ptt_sync_edge.sv
// Selects one sync pin, applies optional inversion, synchronises it with
// two flops and emits a one-cycle start strobe on the chosen edge type.
// Assumes the pins are asynchronous and slow relative to clk.
module ptt_sync_edge
    import ptt_pkg::*;
#(
    parameter int N_SRC = 4,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pins,
    input  logic [SEL_W-1:0] sel,
    input  logic             inv,
    input  logic [1:0]       mode,
    output logic             start
);
    logic picked;
    logic eff;
    logic meta_q, sync_q, prev_q;
    logic rise, fall;

    // Multiplexer over the candidate pins.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) picked = pins[i];
        end
    end

    assign eff = picked ^ inv;

    // Two-flop synchronizer plus history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= eff;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

    // Qualify the detected edge against the selected mode.
    always_comb begin
        unique case (edge_mode_e'(mode))
            EDGE_RISE: start = rise;
            EDGE_FALL: start = fall;
            default:   start = rise | fall;
        endcase
    end
endmodule

// File: rtl/ptt_delay_core.sv
// Holding register, delay down-counter and pulse-width counter.
// A start strobe loads the held delay; each tick decrements it, and when
// a tick finds it at zero the gate is active for PW_TICKS ticks.
// Assumes tick and start are single-cycle strobes in the clk domain.
module ptt_delay_core
    import ptt_pkg::*;
#(
    parameter int DLY_W    = 16,
    parameter int PW_TICKS = 2,
    localparam int PCW = $clog2(PW_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [DLY_W-1:0] dly_wdata,
    input  logic             dly_wr,
    output logic             gate_act,
    output logic             upd_pending,
    output logic             cnt_zero,
    output logic [DLY_W-1:0] shadow
);
    core_state_e      state;
    logic [DLY_W-1:0] dcnt;
    logic [PCW-1:0]   pcnt;

    // Holding register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else if (dly_wr)
            shadow <= dly_wdata;
    end

    // Pending flag: set by a write, cleared when an edge loads the value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_pending <= 1'b0;
        else if (dly_wr)
            upd_pending <= 1'b1;
        else if (start)
            upd_pending <= 1'b0;
    end

    // Delay and pulse sequencing; a start strobe always restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dcnt  <= '0;
            pcnt  <= '0;
        end else if (start) begin
            state <= ST_DELAY;
            dcnt  <= shadow;
            pcnt  <= '0;
        end else if (tick) begin
            unique case (state)
                ST_DELAY: begin
                    if (dcnt == '0) begin
                        state <= ST_PULSE;
                        pcnt  <= PCW'(PW_TICKS - 1);
                    end else begin
                        dcnt <= dcnt - 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (pcnt == '0) state <= ST_IDLE;
                    else            pcnt  <= pcnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign gate_act = (state == ST_PULSE);
    assign cnt_zero = (dcnt == '0);
endmodule

// File: rtl/phase_trigger_timer.sv
// Top level of the phase-control trigger timer: prescaler, sync edge
// front end and delay core. Gate polarity is applied at the output.
// Assumes the control inputs are quasi-static.
module phase_trigger_timer #(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int DLY_W    = 16,
    parameter int PW_TICKS = 2,
    parameter int N_SRC    = 4,
    localparam int SEL_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int TICK_DIV = ptt_pkg::tick_div_calc(longint'(CLK_HZ)),
    localparam int PRESC_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] sync_pins,
    input  logic [SEL_W-1:0] sync_sel,
    input  logic [1:0]       edge_mode,
    input  logic             sync_inv,
    input  logic             gate_inv,
    input  logic [DLY_W-1:0] dly_wdata,
    input  logic             dly_wr,
    output logic             gate_out,
    output logic             upd_pending
);
    logic               tick;
    logic [PRESC_W-1:0] presc_cnt;
    logic               sync_start;
    logic               gate_act;
    logic               cnt_zero;
    logic [DLY_W-1:0]   dly_shadow;

    ptt_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt_o (presc_cnt)
    );

    ptt_sync_edge #(.N_SRC(N_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (sync_pins),
        .sel   (sync_sel),
        .inv   (sync_inv),
        .mode  (edge_mode),
        .start (sync_start)
    );

    ptt_delay_core #(.DLY_W(DLY_W), .PW_TICKS(PW_TICKS)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start       (sync_start),
        .dly_wdata   (dly_wdata),
        .dly_wr      (dly_wr),
        .gate_act    (gate_act),
        .upd_pending (upd_pending),
        .cnt_zero    (cnt_zero),
        .shadow      (dly_shadow)
    );

    // Output polarity selection.
    assign gate_out = gate_act ^ gate_inv;
endmodule

// File: rtl/ptt_checker.sv
// Property checker for phase_trigger_timer, attached through bind.
module ptt_checker #(
    parameter int DLY_W = 16,
    parameter int CW    = 1,
    parameter int DIV   = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CW-1:0]    presc_cnt,
    input logic             sync_start,
    input logic             gate_act,
    input logic             cnt_zero,
    input logic [DLY_W-1:0] dly_shadow,
    input logic             dly_wr,
    input logic             upd_pending
);
    p_presc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        presc_cnt <= CW'(DIV - 1));

    p_gate_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_act != $past(gate_act)) |-> ($past(tick) || $past(sync_start)));

    p_rise_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_act) |-> $past(cnt_zero && tick && !sync_start));

    p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dly_wr) |-> $stable(dly_shadow));

    p_restart_drops_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_start |=> !gate_act);

    p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_pending) |-> $past(dly_wr));

    p_pend_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_start && !dly_wr) |=> !upd_pending);
endmodule

bind phase_trigger_timer ptt_checker #(
    .DLY_W (DLY_W),
    .CW    (PRESC_W),
    .DIV   (TICK_DIV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .presc_cnt   (presc_cnt),
    .sync_start  (sync_start),
    .gate_act    (gate_act),
    .cnt_zero    (cnt_zero),
    .dly_shadow  (dly_shadow),
    .dly_wr      (dly_wr),
    .upd_pending (upd_pending)
);

// File: tb/phase_trigger_timer_tb.sv
module phase_trigger_timer_tb;
    localparam int CLK_PER = 10;
    localparam int unsigned CLK_HZ = 156_250;
    localparam int DW   = 8;
    localparam int PW   = 2;
    localparam int NS   = 4;
    localparam int TDIV = int'((longint'(CLK_HZ) * 256 + 5_000_000) / 10_000_000);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] sync_pins = '0;
    logic [1:0]    sync_sel = '0;
    logic [1:0]    edge_mode = 2'd2;
    logic          sync_inv = 1'b0;
    logic          gate_inv = 1'b0;
    logic [DW-1:0] dly_wdata = '0;
    logic          dly_wr = 1'b0;
    logic          gate_out;
    logic          upd_pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    phase_trigger_timer #(.CLK_HZ(CLK_HZ), .DLY_W(DW), .PW_TICKS(PW), .N_SRC(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .sync_pins(sync_pins), .sync_sel(sync_sel),
        .edge_mode(edge_mode), .sync_inv(sync_inv), .gate_inv(gate_inv),
        .dly_wdata(dly_wdata), .dly_wr(dly_wr), .gate_out(gate_out),
        .upd_pending(upd_pending)
    );

    task automatic chk(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic write_dly(input int d);
        dly_wdata = DW'(d);
        dly_wr = 1'b1;
        @(posedge clk); #1;
        dly_wr = 1'b0;
    endtask

    // Drive one pin level, then watch the gate for 'limit' edges.
    task automatic run_edge(input int pin, input logic lvl, input int limit,
                            input int wr_at, input int wr_val,
                            output int lat, output int wid);
        lat = -1;
        wid = 0;
        sync_pins[pin] = lvl;
        for (int n = 1; n <= limit; n++) begin
            if (n == wr_at) begin
                dly_wdata = DW'(wr_val);
                dly_wr = 1'b1;
            end
            @(posedge clk); #1;
            dly_wr = 1'b0;
            if (gate_out ^ gate_inv) begin
                if (lat < 0) lat = n;
                wid++;
            end
        end
    endtask

    function automatic int win(input int d);
        return (d + PW + 1) * TDIV + 8;
    endfunction

    int lat, wid;

    initial begin
        cyc(5);
        rst_n = 1'b1;
        // R11: inactive output and no pending flag after reset
        cyc(1);
        chk("R11 gate idle", int'(gate_out), 0, 0);
        chk("R11 pending", int'(upd_pending), 0, 0);
        begin
            int seen = 0;
            for (int i = 0; i < 60; i++) begin
                cyc(1);
                if (gate_out) seen++;
            end
            chk("R11 no pulse before edge", seen, 0, 0);
        end

        // R10: pending flag follows a write
        write_dly(2);
        chk("R10 pending set", int'(upd_pending), 1, 1);

        // R1 R7 R9: all edge modes, both sync polarities
        for (int m = 0; m < 4; m++) begin
            for (int iv = 0; iv < 2; iv++) begin
                int pin = (m * 2 + iv) % NS;
                int other = (pin + 1) % NS;
                edge_mode = 2'(m);
                sync_inv = iv[0];
                sync_sel = 2'(pin);
                cyc(100);
                run_edge(other, ~sync_pins[other], win(2), -1, 0, lat, wid);
                chk("R9 unselected pin ignored", wid, 0, 0);
                run_edge(other, ~sync_pins[other], win(2), -1, 0, lat, wid);
                chk("R9 unselected pin ignored", wid, 0, 0);
                for (int k = 0; k < 2; k++) begin
                    logic nl;
                    logic eff_rise;
                    bit want;
                    nl = ~sync_pins[pin];
                    eff_rise = nl ^ iv[0];
                    want = (m >= 2) || (m == 0 && eff_rise) || (m == 1 && !eff_rise);
                    run_edge(pin, nl, win(2), -1, 0, lat, wid);
                    if (want) begin
                        chk(iv ? "R7 inverted sync width" : "R1 edge mode width", wid, PW*TDIV, PW*TDIV);
                        chk(iv ? "R7 inverted sync latency" : "R1 edge mode latency", lat, 2*TDIV+4, 3*TDIV+3);
                        chk("R10 pending cleared", int'(upd_pending), 0, 0);
                    end else begin
                        chk(iv ? "R7 inverted sync no pulse" : "R1 non-qualifying edge", wid, 0, 0);
                    end
                end
            end
        end

        // R2 R3 R4: delay sweep in both-edge mode
        edge_mode = 2'd2;
        sync_inv = 1'b0;
        sync_sel = 2'd0;
        cyc(100);
        for (int d = 0; d <= 24; d++) begin
            write_dly(d);
            run_edge(0, ~sync_pins[0], win(d), -1, 0, lat, wid);
            chk(d == 0 ? "R4 zero delay latency" : "R3 delay latency", lat, d*TDIV+4, d*TDIV+TDIV+3);
            chk("R2 pulse width", wid, PW*TDIV, PW*TDIV);
        end
        write_dly((1 << DW) - 1);
        run_edge(0, ~sync_pins[0], win((1 << DW) - 1), -1, 0, lat, wid);
        chk("R3 max delay latency", lat, ((1<<DW)-1)*TDIV+4, ((1<<DW)-1)*TDIV+TDIV+3);
        chk("R2 max delay width", wid, PW*TDIV, PW*TDIV);

        // R5: write during a running delay changes only the next one
        write_dly(10);
        run_edge(0, ~sync_pins[0], win(10), 6, 3, lat, wid);
        chk("R5 running delay keeps old value", lat, 10*TDIV+4, 11*TDIV+3);
        chk("R10 pending after mid-delay write", int'(upd_pending), 1, 1);
        run_edge(0, ~sync_pins[0], win(3), -1, 0, lat, wid);
        chk("R5 new value on next edge", lat, 3*TDIV+4, 4*TDIV+3);

        // R6: a second edge mid-delay restarts the count
        write_dly(10);
        run_edge(0, ~sync_pins[0], win(3), -1, 0, lat, wid);
        run_edge(0, ~sync_pins[0], 20, -1, 0, lat, wid);
        chk("R6 no pulse before restart", wid, 0, 0);
        run_edge(0, ~sync_pins[0], win(10), -1, 0, lat, wid);
        chk("R6 latency from restart edge", lat, 10*TDIV+4, 11*TDIV+3);

        // R8: inverted output polarity
        write_dly(2);
        gate_inv = 1'b1;
        cyc(2);
        chk("R8 inverted idle level", int'(gate_out), 1, 1);
        run_edge(0, ~sync_pins[0], win(2), -1, 0, lat, wid);
        chk("R8 inverted pulse width", wid, PW*TDIV, PW*TDIV);
        chk("R8 inverted pulse latency", lat, 2*TDIV+4, 3*TDIV+3);
        chk("R8 returns to idle", int'(gate_out), 1, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule